// File: doc/BRIEF.md
# Asynchronous Static RAM Bus Controller

This block lets a clocked system read and write one byte at a time in an external asynchronous static RAM of 256K bytes. A requester offers an operation through a valid/ready handshake with a write flag, an 18-bit address and a write byte. Reads come back as a byte with a one-cycle valid strobe. Toward the memory the block drives the address, an active-low primary select, an active-high secondary select, an active-low output enable and an active-low write enable. It also drives a data bus whose output, enable and input are kept as separate signals, so the tri-state pad can sit at the chip edge.

All of the memory's minimum intervals are held as nanosecond parameters. They are turned into cycle counts by rounding up against the clock-period parameter `CLK_NS`. These intervals are access time, output-enable access, cycle time, write pulse width, address and data setup to write end, and the two bus-release windows. A generate-time check rejects a clock period above 30 ns. A separate standby input parks the memory in its low-power retention state. When that input drops, the block waits one full cycle time before it accepts a new request.

The controller is one state machine with eight states.
- `ST_IDLE` moves to `ST_SLEEP` when standby is asked. Otherwise an accepted read moves it to `ST_READ` and an accepted write to `ST_WSETUP`.
- `ST_READ` moves to `ST_RREL` when its timer expires. The read byte is captured on that edge.
- `ST_RREL` moves to `ST_IDLE` when its timer expires.
- `ST_WSETUP` moves to `ST_WPULSE` after one cycle.
- `ST_WPULSE` moves to `ST_WHOLD` when its timer expires.
- `ST_WHOLD` moves to `ST_IDLE` after one cycle.
- `ST_SLEEP` moves to `ST_WAKE` when standby is released.
- `ST_WAKE` moves to `ST_IDLE` when its timer expires.

Top module: `sram_ctrl`

## Requirements
- R1: In reset and in idle: primary select high, secondary select high, output enable high, write enable high, data drive off and no read strobe. `req_ready` is high while `sleep_req` is low.
- R2: An accepted read holds the primary select low, output enable low and write enable high for C_RD = ceil(max(70, 35) ns / CLK_NS) cycles (18 at 4 ns). The data bus is sampled on the last of these edges. `rsp_valid` is high for exactly one cycle, C_RD cycles after the accepting edge.
- R3: An accepted write gives one setup cycle with the select low and write enable high. Then write enable is low for C_WP cycles (17 at 4 ns), where C_WP = max(ceil(60/P), ceil(33/P)+ceil(30/P), ceil(65/P)-1, ceil(70/P)-2). One hold cycle follows with write enable high. `req_ready` returns C_WP+2 cycles after the accepting edge, and the byte is stored at the address.
- R4: At the memory, write enable stays low for at least 60 ns. Data is driven at least 30 ns before write enable rises, and the address is stable at least 65 ns before it rises. The select stays low for at least 70 ns in any access.
- R5: The data bus is driven only during the last C_WP - ceil(33/P) cycles of the write-enable-low window and the following hold cycle. It is never driven while output enable is low, nor within 25 ns after output enable rises. A read is followed by ceil(25/P) release cycles (7 at 4 ns) before `req_ready` returns.
- R6: Output enable is low only during reads, and it is never low together with write enable.
- R7: While `sleep_req` is high with no access in flight, the block enters standby. The secondary select is low, the primary select is high, the strobes are high and `req_ready` is low, so requests presented then are ignored and leave memory unchanged.
- R8: After `sleep_req` falls, the secondary select returns high at once. `req_ready` stays low for ceil(70/P) cycles (18 at 4 ns) before it rises.
- R9: While the primary select is low, the address bus holds the accepted address without change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous release |
| sleep_req | input | 1 | Request to park the memory in standby |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request accepted this cycle when valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 18 | Byte address |
| req_wdata | input | 8 | Write byte |
| rsp_valid | output | 1 | One-cycle strobe for read data |
| rsp_rdata | output | 8 | Read byte |
| mem_addr | output | 18 | Memory address bus |
| mem_ce1_n | output | 1 | Primary select, active low |
| mem_ce2 | output | 1 | Secondary select, active high |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_we_n | output | 1 | Memory write enable, active low |
| mem_dq_out | output | 8 | Data toward memory |
| mem_dq_oe | output | 1 | Enable for the data pad drivers |
| mem_dq_in | input | 8 | Data from memory |

## Verification
The bench's memory model returns the inverted byte until address access, output-enable access and select access have all elapsed. A controller that sampled one cycle early would therefore read the wrong byte instead of a lucky right one. A timing monitor stamps each edge in nanoseconds. It catches a write pulse that is too short, data driven with less than 30 ns of setup, and any drive of the bus inside the 25 ns output-enable release window or the 33 ns write-enable window, the way a controller that skipped the release cycles would. A read followed at once by a write and standby entered with a request pending are both exercised. Any request that slipped through during standby would show up as corrupted data on the later read-back.

// File: rtl/sram_ctrl_pkg.sv
`timescale 1ns/100ps
package sram_ctrl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ,
        ST_RREL,
        ST_WSETUP,
        ST_WPULSE,
        ST_WHOLD,
        ST_SLEEP,
        ST_WAKE
    } ctrl_state_t;

    // Round a nanosecond interval up to whole clock cycles.
    function automatic int ns2cyc(input int ns, input int clk_ns);
        return (ns + clk_ns - 1) / clk_ns;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_ctrl_timer.sv
`timescale 1ns/100ps
// Down counter: load sets the remaining count, done when it reaches zero.
module sram_ctrl_timer #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic [W-1:0] cnt,
    output logic         done
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign done = (cnt == '0);

endmodule

// File: rtl/sram_ctrl_capture.sv
`timescale 1ns/100ps
// Registers the sampled read byte and raises a one-cycle strobe.
module sram_ctrl_capture #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          capture,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] dout,
    output logic          strobe
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout   <= '0;
            strobe <= 1'b0;
        end else begin
            strobe <= capture;
            if (capture) begin
                dout <= din;
            end
        end
    end

endmodule

// File: rtl/sram_ctrl.sv
`timescale 1ns/100ps
module sram_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int CLK_NS = 4,
    parameter int AW     = 18,
    parameter int DW     = 8,
    parameter int T_RC   = 70,   // read cycle
    parameter int T_AA   = 70,   // address access
    parameter int T_DOE  = 35,   // output-enable access
    parameter int T_OHZ  = 25,   // bus release after output enable rises
    parameter int T_WHZ  = 33,   // bus release after write enable falls
    parameter int T_WP   = 60,   // write pulse
    parameter int T_WC   = 70,   // write cycle
    parameter int T_AW   = 65,   // address setup to write end
    parameter int T_DW   = 30    // data setup to write end
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sleep_req,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic          req_write,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    output logic          rsp_valid,
    output logic [DW-1:0] rsp_rdata,
    output logic [AW-1:0] mem_addr,
    output logic          mem_ce1_n,
    output logic          mem_ce2,
    output logic          mem_oe_n,
    output logic          mem_we_n,
    output logic [DW-1:0] mem_dq_out,
    output logic          mem_dq_oe,
    input  logic [DW-1:0] mem_dq_in
);

    localparam int C_RD    = imax(ns2cyc(T_AA, CLK_NS), ns2cyc(T_DOE, CLK_NS));
    localparam int C_RREL  = imax(imax(ns2cyc(T_OHZ, CLK_NS), ns2cyc(T_RC, CLK_NS) - C_RD), 1);
    localparam int C_WHZ   = ns2cyc(T_WHZ, CLK_NS);
    localparam int C_PULSE = imax(imax(ns2cyc(T_WP, CLK_NS), C_WHZ + ns2cyc(T_DW, CLK_NS)),
                                  imax(ns2cyc(T_AW, CLK_NS) - 1, ns2cyc(T_WC, CLK_NS) - 2));
    localparam int C_DRIVE = C_PULSE - C_WHZ;
    localparam int C_WAKE  = imax(ns2cyc(T_RC, CLK_NS), 1);
    localparam int C_MAX   = imax(imax(C_RD, C_RREL), imax(C_PULSE, C_WAKE));
    localparam int TW      = $clog2(C_MAX + 1);

    // A period longer than the shortest setup window leaves no room for the guard cycles.
    if (CLK_NS < 1 || CLK_NS > T_DW) begin : g_bad_clk
        $error("sram_ctrl: CLK_NS out of range");
    end

    ctrl_state_t    state, nstate;
    logic [AW-1:0]  addr_q;
    logic [DW-1:0]  wdata_q;
    logic           accept;
    logic           tmr_load;
    logic [TW-1:0]  tmr_val;
    logic [TW-1:0]  tmr_cnt;
    logic           tmr_done;
    logic           rd_capture;

    assign req_ready  = (state == ST_IDLE) && !sleep_req;
    assign accept     = req_valid && req_ready;
    assign mem_addr   = addr_q;
    assign mem_dq_out = wdata_q;

    // State register and request capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            addr_q  <= '0;
            wdata_q <= '0;
        end else begin
            state <= nstate;
            if (accept) begin
                addr_q  <= req_addr;
                wdata_q <= req_wdata;
            end
        end
    end

    // Transitions and timer loads.
    always_comb begin
        nstate     = state;
        tmr_load   = 1'b0;
        tmr_val    = '0;
        rd_capture = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (sleep_req) begin
                    nstate = ST_SLEEP;
                end else if (req_valid) begin
                    tmr_load = 1'b1;
                    if (req_write) begin
                        nstate = ST_WSETUP;
                    end else begin
                        nstate  = ST_READ;
                        tmr_val = TW'(C_RD - 1);
                    end
                end
            end
            ST_READ: begin
                if (tmr_done) begin
                    nstate     = ST_RREL;
                    rd_capture = 1'b1;
                    tmr_load   = 1'b1;
                    tmr_val    = TW'(C_RREL - 1);
                end
            end
            ST_RREL: begin
                if (tmr_done) nstate = ST_IDLE;
            end
            ST_WSETUP: begin
                nstate   = ST_WPULSE;
                tmr_load = 1'b1;
                tmr_val  = TW'(C_PULSE - 1);
            end
            ST_WPULSE: begin
                if (tmr_done) nstate = ST_WHOLD;
            end
            ST_WHOLD: begin
                nstate = ST_IDLE;
            end
            ST_SLEEP: begin
                if (!sleep_req) begin
                    nstate   = ST_WAKE;
                    tmr_load = 1'b1;
                    tmr_val  = TW'(C_WAKE - 1);
                end
            end
            ST_WAKE: begin
                if (tmr_done) nstate = ST_IDLE;
            end
            default: nstate = ST_IDLE;
        endcase
    end

    // Memory strobes decoded from the state register.
    always_comb begin
        mem_ce1_n = 1'b1;
        mem_ce2   = 1'b1;
        mem_oe_n  = 1'b1;
        mem_we_n  = 1'b1;
        mem_dq_oe = 1'b0;
        unique case (state)
            ST_READ: begin
                mem_ce1_n = 1'b0;
                mem_oe_n  = 1'b0;
            end
            ST_WSETUP: begin
                mem_ce1_n = 1'b0;
            end
            ST_WPULSE: begin
                mem_ce1_n = 1'b0;
                mem_we_n  = 1'b0;
                mem_dq_oe = (tmr_cnt < TW'(C_DRIVE));
            end
            ST_WHOLD: begin
                mem_ce1_n = 1'b0;
                mem_dq_oe = 1'b1;
            end
            ST_SLEEP: begin
                mem_ce2 = 1'b0;
            end
            ST_IDLE, ST_RREL, ST_WAKE: begin
            end
            default: begin
            end
        endcase
    end

    sram_ctrl_timer #(.W(TW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .cnt      (tmr_cnt),
        .done     (tmr_done)
    );

    sram_ctrl_capture #(.DW(DW)) u_capture (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (rd_capture),
        .din     (mem_dq_in),
        .dout    (rsp_rdata),
        .strobe  (rsp_valid)
    );

endmodule

// File: rtl/sram_ctrl_chk.sv
`timescale 1ns/100ps
module sram_ctrl_chk
    import sram_ctrl_pkg::*;
#(
    parameter int CLK_NS = 4,
    parameter int AW     = 18,
    parameter int T_WP   = 60,
    parameter int T_OHZ  = 25
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_ready,
    input logic          rsp_valid,
    input logic [AW-1:0] mem_addr,
    input logic          mem_ce1_n,
    input logic          mem_ce2,
    input logic          mem_oe_n,
    input logic          mem_we_n,
    input logic          mem_dq_oe
);

    localparam int C_WPMIN = ns2cyc(T_WP, CLK_NS);
    localparam int C_OHZ   = ns2cyc(T_OHZ, CLK_NS);

    logic [5:0] we_low_cnt;
    logic [5:0] oe_high_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            we_low_cnt  <= '0;
            oe_high_cnt <= '1;
        end else begin
            we_low_cnt  <= mem_we_n ? '0 : ((we_low_cnt == '1) ? we_low_cnt : we_low_cnt + 1'b1);
            oe_high_cnt <= !mem_oe_n ? '0 : ((oe_high_cnt == '1) ? oe_high_cnt : oe_high_cnt + 1'b1);
        end
    end

    // R2
    rsp_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(!mem_oe_n));

    // R3
    we_selected_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> (!mem_ce1_n && mem_ce2));

    // R4
    we_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we_n && $past(!mem_we_n)) |-> (we_low_cnt >= 6'(C_WPMIN)));

    // R5
    no_drive_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> mem_oe_n);

    // R5
    drive_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> (oe_high_cnt >= 6'(C_OHZ)));

    // R6
    oe_we_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(!mem_oe_n && !mem_we_n));

    // R7
    sleep_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_ce2 |-> (mem_ce1_n && mem_oe_n && mem_we_n && !mem_dq_oe && !req_ready));

    // R8
    wake_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_ce2) |-> !req_ready);

    // R9
    addr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_ce1_n && $past(!mem_ce1_n)) |-> $stable(mem_addr));

endmodule

bind sram_ctrl sram_ctrl_chk #(
    .CLK_NS (CLK_NS),
    .AW     (AW),
    .T_WP   (T_WP),
    .T_OHZ  (T_OHZ)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_ready (req_ready),
    .rsp_valid (rsp_valid),
    .mem_addr  (mem_addr),
    .mem_ce1_n (mem_ce1_n),
    .mem_ce2   (mem_ce2),
    .mem_oe_n  (mem_oe_n),
    .mem_we_n  (mem_we_n),
    .mem_dq_oe (mem_dq_oe)
);

// File: tb/sram_ctrl_bench.sv
`timescale 1ns/100ps
module sram_ctrl_bench;

    localparam int P = 4;
    function automatic int cyc(input int ns);
        return (ns + P - 1) / P;
    endfunction
    function automatic int mx(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    localparam int E_RD    = mx(cyc(70), cyc(35));
    localparam int E_RREL  = mx(cyc(25), cyc(70) - E_RD);
    localparam int E_WHZ   = cyc(33);
    localparam int E_PULSE = mx(mx(cyc(60), E_WHZ + cyc(30)), mx(cyc(65) - 1, cyc(70) - 2));
    localparam int E_WAKE  = cyc(70);

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sleep_req = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [17:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        rsp_valid;
    logic [7:0]  rsp_rdata;
    logic [17:0] mem_addr;
    logic        mem_ce1_n, mem_ce2, mem_oe_n, mem_we_n, mem_dq_oe;
    logic [7:0]  mem_dq_out;
    logic [7:0]  mem_dq_in = 8'hEE;

    int errors = 0;
    int checks = 0;

    always #2 clk = ~clk;

    sram_ctrl u_sram_ctrl (
        .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .mem_addr(mem_addr), .mem_ce1_n(mem_ce1_n), .mem_ce2(mem_ce2),
        .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
        .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // ---------------- memory model and timing monitor ----------------
    logic [7:0] marr [int];
    logic [7:0] sb   [int];
    realtime t_addr = -1000.0, t_oe_fall = -1000.0, t_oe_rise = -1000.0;
    realtime t_ce_fall = -1000.0, t_we_fall = -1000.0, t_dq = -1000.0;

    always @(mem_addr)        t_addr    = $realtime;
    always @(negedge mem_oe_n) t_oe_fall = $realtime;
    always @(posedge mem_oe_n) t_oe_rise = $realtime;
    always @(negedge mem_ce1_n) t_ce_fall = $realtime;
    always @(negedge mem_we_n) t_we_fall = $realtime;
    always @(mem_dq_out or posedge mem_dq_oe) t_dq = $realtime;

    // Output of the memory: inverted byte until every access time has elapsed.
    initial begin
        #0.5;
        forever begin
            if (!mem_ce1_n && mem_ce2 && mem_we_n && !mem_oe_n) begin
                logic [7:0] v;
                v = marr.exists(int'(mem_addr)) ? marr[int'(mem_addr)] : 8'hA5;
                if (($realtime - t_addr >= 70.0) && ($realtime - t_oe_fall >= 35.0) &&
                    ($realtime - t_ce_fall >= 70.0))
                    mem_dq_in = v;
                else
                    mem_dq_in = ~v;
            end else begin
                mem_dq_in = 8'hEE;
            end
            #1;
        end
    end

    always @(posedge mem_we_n) begin
        if (rst_n && !mem_ce1_n && mem_ce2) begin
            check($realtime - t_we_fall >= 60.0, "R4", "write pulse ns", int'($realtime - t_we_fall), 60);
            check(mem_dq_oe && ($realtime - t_dq >= 30.0), "R4", "data setup ns", int'($realtime - t_dq), 30);
            check($realtime - t_addr >= 65.0, "R4", "address setup ns", int'($realtime - t_addr), 65);
            marr[int'(mem_addr)] = mem_dq_out;
        end
    end

    always @(posedge mem_ce1_n) begin
        if (rst_n) check($realtime - t_ce_fall >= 65.0 + 5.0, "R4", "select low ns",
                         int'($realtime - t_ce_fall), 70);
    end

    always @(posedge mem_dq_oe) begin
        if (rst_n) begin
            check(mem_oe_n && ($realtime - t_oe_rise >= 25.0), "R5", "drive after OE release ns",
                  int'($realtime - t_oe_rise), 25);
            check(!mem_we_n && ($realtime - t_we_fall >= 33.0), "R5", "drive after WE fall ns",
                  int'($realtime - t_we_fall), 33);
        end
    end

    // ---------------- scenario tasks ----------------
    task automatic do_write(input logic [17:0] a, input logic [7:0] d);
        int n = 1, we_low = 0, dq_on = 0, oe_low = 0, addr_bad = 0;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0;
        while (!req_ready && n < 200) begin
            if (!mem_we_n) we_low++;
            if (mem_dq_oe) dq_on++;
            if (!mem_oe_n) oe_low++;
            if (!mem_ce1_n && mem_addr != a) addr_bad++;
            @(negedge clk); n++;
        end
        check(we_low == E_PULSE, "R3", "write enable low cycles", we_low, E_PULSE);
        check(n == E_PULSE + 3, "R3", "write ready return", n, E_PULSE + 3);
        check(dq_on == E_PULSE - E_WHZ + 1, "R5", "drive cycles", dq_on, E_PULSE - E_WHZ + 1);
        check(oe_low == 0, "R6", "OE low during write", oe_low, 0);
        check(addr_bad == 0, "R9", "address changes in write", addr_bad, 0);
        sb[int'(a)] = d;
    endtask

    task automatic do_read(input logic [17:0] a, input logic [7:0] exp);
        int n = 1, oe_low = 0, addr_bad = 0, rsp_at = 0, rsp_cnt = 0;
        logic [7:0] got = '0;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a;
        @(negedge clk);
        req_valid = 1'b0;
        while (!req_ready && n < 200) begin
            if (!mem_oe_n) oe_low++;
            if (!mem_ce1_n && mem_addr != a) addr_bad++;
            if (rsp_valid) begin
                rsp_cnt++;
                if (rsp_at == 0) begin rsp_at = n; got = rsp_rdata; end
            end
            @(negedge clk); n++;
        end
        check(got == exp, "R2", "read data", int'(got), int'(exp));
        check(rsp_at == E_RD + 1, "R2", "read strobe latency", rsp_at, E_RD + 1);
        check(rsp_cnt == 1, "R2", "read strobe width", rsp_cnt, 1);
        check(oe_low == E_RD, "R6", "OE low cycles", oe_low, E_RD);
        check(n == E_RD + E_RREL + 1, "R5", "release before ready", n, E_RD + E_RREL + 1);
        check(addr_bad == 0, "R9", "address changes in read", addr_bad, 0);
    endtask

    task automatic t_reset;
        @(negedge clk);
        check(mem_ce1_n && mem_ce2 && mem_oe_n && mem_we_n && !mem_dq_oe && !rsp_valid,
              "R1", "strobes in reset", 0, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(req_ready == 1'b1, "R1", "ready after reset", int'(req_ready), 1);
        check(mem_ce1_n && mem_ce2 && mem_oe_n && mem_we_n && !mem_dq_oe,
              "R1", "idle strobes", 0, 0);
    endtask

    task automatic t_boundary;
        do_write(18'h00000, 8'h00);
        do_write(18'h3FFFF, 8'hFF);
        do_write(18'h12345, 8'h5A);
        do_read(18'h3FFFF, 8'hFF);
        do_read(18'h00000, 8'h00);
        do_read(18'h12345, 8'h5A);
    endtask

    task automatic t_turnaround;
        do_write(18'h2AAAA, 8'hA5);
        do_read(18'h2AAAA, 8'hA5);
        do_write(18'h2AAAA, 8'h3C);
        do_read(18'h2AAAA, 8'h3C);
    endtask

    task automatic t_sleep;
        int n = 1;
        bit ready_seen = 1'b0;
        do_write(18'h01234, 8'h77);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        sleep_req = 1'b1;
        req_valid = 1'b1; req_write = 1'b1; req_addr = 18'h01234; req_wdata = 8'h88;
        @(negedge clk);
        check(!mem_ce2 && mem_ce1_n, "R7", "standby selects", int'(mem_ce2), 0);
        for (int i = 0; i < 6; i++) begin
            if (req_ready) ready_seen = 1'b1;
            @(negedge clk);
        end
        check(!ready_seen, "R7", "ready during standby", int'(ready_seen), 0);
        req_valid = 1'b0;
        @(negedge clk);
        sleep_req = 1'b0;
        @(negedge clk);
        check(mem_ce2 == 1'b1, "R8", "secondary select after wake", int'(mem_ce2), 1);
        while (!req_ready && n < 200) begin
            @(negedge clk); n++;
        end
        check(n == E_WAKE + 1, "R8", "wake wait cycles", n, E_WAKE + 1);
        do_read(18'h01234, 8'h77);  // R7: the request during standby left memory unchanged
    endtask

    task automatic t_random;
        logic [15:0] lfsr = 16'hACE1;
        for (int i = 0; i < 24; i++) begin
            logic [17:0] a;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            a = {lfsr[3:0], 14'h0155};
            if (lfsr[8] || !sb.exists(int'(a))) do_write(a, lfsr[15:8] ^ lfsr[7:0]);
            else do_read(a, sb[int'(a)]);
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        t_reset();
        t_boundary();
        t_turnaround();
        t_sleep();
        t_random();
        repeat (4) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=expired expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule